// File: doc/BRIEF.md
# Programmable SPI Serial Clock Divider

This block derives the serial clock for an SPI engine from a fast source clock. Two counters run in series. A prescaler issues a step pulse once every P source cycles. A period counter advances on each step and counts 0..N-1. The output level at each count is set by a high point H and a low-return point L, which together give the duty cycle. The serial clock period is therefore P×N source cycles. A bypass setting sends the source clock straight to the output for the fastest rate.

Alongside the clock, the block gives the SPI engine two single-cycle strobes. One marks the cycle in which the serial clock went high and the other the cycle in which it went low. While the divider is disabled, the output rests at an idle level chosen by the engine. The divider values are computed elsewhere and arrive as one packed word. The block stores that word in a shadow copy and applies it only at period boundaries, so a reconfiguration never produces a runt pulse.

Top module: `sclk_div_gen`

## Requirements
- R1: While `div_en` is low, `sclk_o` equals `idle_pol`, both tick outputs are 0 and both counters are held at zero.
- R2: With bypass clear and L = N, `sclk_o` repeats every P×N source cycles, where P and N are the field values plus one.
- R3: Within each period, `sclk_o` is high for the first P×H source cycles and low for the remaining P×(N−H) cycles.
- R4: The first clock edge that samples `div_en` high starts a full high phase. Every later level lasts its full P-cycle multiple, with no shortened first phase.
- R5: `rise_tick_o` is 1 for exactly the cycle in which `sclk_o` has just gone from 0 to 1, and `fall_tick_o` likewise for 1 to 0. The two never coincide outside bypass.
- R6: A new `cfg_word` presented while running has no effect until the period counter wraps. The first full period after that wrap uses the new values.
- R7: When the bypass bit is set and `div_en` is high, `sclk_o` follows the source clock, and both ticks are 1 in every cycle after the first edge. When `div_en` is low, the idle level still wins.
- R8: For a count value c, the output level is high when c < H or when c ≥ L. Programming L below N therefore returns the clock high before the wrap.
- R9: Dropping `div_en` returns `sclk_o` to `idle_pol` at the next edge. Raising it again restarts from count zero with a full first phase.
- R10: `cfg_word` layout: bit 0 bypass; bits [13:1] P−1; bits [19:14] N−1; bits [25:20] H−1; bits [31:26] L−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_en | input | 1 | Run the divider; low holds the idle level |
| idle_pol | input | 1 | Level of the serial clock while idle |
| cfg_word | input | 32 | Packed divider setting (layout in R10) |
| sclk_o | output | 1 | Divided serial clock |
| rise_tick_o | output | 1 | One-cycle strobe after a 0→1 transition of sclk_o |
| fall_tick_o | output | 1 | One-cycle strobe after a 1→0 transition of sclk_o |

## Verification
Several properties are checked on every cycle: both counters stay within their programmed bounds, the idle level appears after any disabled cycle, each tick agrees with the actual transition of the registered clock, the two ticks are never high together, the shadow setting stays frozen between wraps, and the bypass strobes follow the bypass state. Other behaviours can only be shown by the bench's scenarios, because each spans a whole period. These are the exact period and duty-cycle lengths for several P/N/H/L mixes, the full first phase after enable, the return-high point when L is below N, the boundary at which a mid-period reconfiguration lands, and the pass-through of the source clock in bypass.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int PRE_W = 13;
  localparam int CNT_W = 6;
  localparam int CFG_W = 1 + PRE_W + 3 * CNT_W;

  // bit 0 is bypass; fields follow upward in declaration order reversed
  typedef struct packed {
    logic [CNT_W-1:0] low_m1;
    logic [CNT_W-1:0] high_m1;
    logic [CNT_W-1:0] per_m1;
    logic [PRE_W-1:0] pre_m1;
    logic             bypass;
  } sdv_cfg_t;

  // Level for a given period count: high below H, high again at or past L.
  function automatic logic phase_level(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] high_m1,
                                       input logic [CNT_W-1:0] low_m1);
    return (cnt <= high_m1) || (cnt > low_m1);
  endfunction
endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale
  import sclk_div_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] pre_m1,
  output logic         step_o
);
  logic [W-1:0] pcnt_q;

  assign step_o = run && (pcnt_q == pre_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt_q <= '0;
    else if (!run || step_o) pcnt_q <= '0;
    else                     pcnt_q <= pcnt_q + 1'b1;
  end

  // R2: prescale count never passes the programmed terminal value
  a_r2_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= pre_m1);

  // R1: counter parked at zero after an idle cycle
  a_r1_pre_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pcnt_q == '0);
endmodule

// File: rtl/sclk_period_cnt.sv
module sclk_period_cnt
  import sclk_div_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] per_m1,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = step && (cnt_q == per_m1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  // R2: period count stays inside 0..N-1
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_m1);

  // R2: count holds between prescaler steps
  a_r2_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/sclk_shape.sv
module sclk_shape (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic idle_pol,
  input  logic level,
  output logic sclk_q,
  output logic rise_o,
  output logic fall_o
);
  logic next_lvl;

  assign next_lvl = run ? level : idle_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      sclk_q <= next_lvl;
      rise_o <= run && next_lvl && !sclk_q;
      fall_o <= run && !next_lvl && sclk_q;
    end
  end

  // R1: idle level follows any cycle spent disabled
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk_q == $past(idle_pol)) && !rise_o && !fall_o);

  // R5: rise strobe only when the clock really went up
  a_r5_rise_real: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> (sclk_q && !$past(sclk_q)));

  // R5: fall strobe only when the clock really went down
  a_r5_fall_real: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (!sclk_q && $past(sclk_q)));

  // R5: strobes are mutually exclusive
  a_r5_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/sclk_div_gen.sv
module sclk_div_gen
  import sclk_div_pkg::*;
#(
  parameter int CW = CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          div_en,
  input  logic          idle_pol,
  input  logic [CW-1:0] cfg_word,
  output logic          sclk_o,
  output logic          rise_tick_o,
  output logic          fall_tick_o
);
  sdv_cfg_t         act_q;
  sdv_cfg_t         cfg_in;
  logic             run;
  logic             byp_run;
  logic             step;
  logic             wrap;
  logic             load;
  logic [CNT_W-1:0] cnt;
  logic             level;
  logic             sclk_div;
  logic             rise_div;
  logic             fall_div;
  logic             byp_tick_q;

  assign cfg_in  = sdv_cfg_t'(cfg_word);
  assign run     = div_en && !act_q.bypass;
  assign byp_run = div_en && act_q.bypass;
  // shadow copy reloads only outside an active divided period
  assign load    = !div_en || act_q.bypass || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (load) act_q <= cfg_in;
  end

  sclk_prescale #(.W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .pre_m1 (act_q.pre_m1),
    .step_o (step)
  );

  sclk_period_cnt #(.W(CNT_W)) u_per (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .step   (step),
    .per_m1 (act_q.per_m1),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  assign level = phase_level(cnt, act_q.high_m1, act_q.low_m1);

  sclk_shape u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .idle_pol (idle_pol),
    .level    (level),
    .sclk_q   (sclk_div),
    .rise_o   (rise_div),
    .fall_o   (fall_div)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_tick_q <= 1'b0;
    else        byp_tick_q <= byp_run;
  end

  assign sclk_o      = byp_run ? clk : sclk_div;
  assign rise_tick_o = byp_tick_q | rise_div;
  assign fall_tick_o = byp_tick_q | fall_div;

  // R6: setting is frozen between wraps while dividing
  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(act_q));

  // R7: bypass running yields both strobes on the following cycle
  a_r7_bypass_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    byp_run |=> (rise_tick_o && fall_tick_o));

  // R9: a disabled cycle leaves no strobe behind
  a_r9_quiet_after_off: assert property (@(posedge clk) disable iff (!rst_n)
    !div_en |=> (!rise_tick_o && !fall_tick_o));
endmodule

// File: tb/sclk_div_gen_tb.sv
module sclk_div_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_en = 1'b0;
  logic        idle_pol = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        sclk_o, rise_tick_o, fall_tick_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  sclk_div_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_en      (div_en),
    .idle_pol    (idle_pol),
    .cfg_word    (cfg_word),
    .sclk_o      (sclk_o),
    .rise_tick_o (rise_tick_o),
    .fall_tick_o (fall_tick_o)
  );

  // R10 field placement, built arithmetically
  function automatic logic [31:0] pack(input int byp, input int p, input int n,
                                       input int h, input int l);
    return 32'(byp) + 32'((p - 1) * 2) + 32'((n - 1) * (1 << 14)) +
           32'((h - 1) * (1 << 20)) + 32'((l - 1) * (1 << 26));
  endfunction

  // Expected level m cycles after the enabling edge (m starts at 1)
  function automatic logic want(input int m, input int p, input int n,
                                input int h, input int l);
    int idx;
    idx = ((m - 1) / p) % n;
    return (idx < h) || (idx >= l);
  endfunction

  task automatic check(input logic got, input logic exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  task automatic check_idle(input logic ip, input string tag);
    check(sclk_o, ip, {tag, " idle level"});
    check(rise_tick_o, 1'b0, {tag, " rise quiet"});
    check(fall_tick_o, 1'b0, {tag, " fall quiet"});
  endtask

  task automatic run_wave(input int p, input int n, input int h, input int l,
                          input logic ip, input int len, input string tag);
    logic prev, e;
    @(negedge clk);
    div_en = 1'b0; idle_pol = ip; cfg_word = pack(0, p, n, h, l);
    @(negedge clk); @(negedge clk);
    check_idle(ip, "R1");
    div_en = 1'b1;
    prev = ip;
    for (int m = 1; m <= len; m++) begin
      @(negedge clk);
      e = want(m, p, n, h, l);
      check(sclk_o, e, tag);
      check(rise_tick_o, e && !prev, "R5 rise tick");
      check(fall_tick_o, !e && prev, "R5 fall tick");
      prev = e;
    end
    div_en = 1'b0;
  endtask

  task automatic t_cfg_change();
    logic prev, e;
    int   t_sw;
    @(negedge clk);
    div_en = 1'b0; idle_pol = 1'b0; cfg_word = pack(0, 1, 6, 3, 6);
    @(negedge clk); @(negedge clk);
    div_en = 1'b1;
    prev = 1'b0;
    for (int m = 1; m <= 4; m++) begin
      @(negedge clk);
      e = want(m, 1, 6, 3, 6);
      check(sclk_o, e, "R6 before change");
      prev = e;
    end
    cfg_word = pack(0, 2, 4, 1, 4);
    t_sw = 6;  // first multiple of 6 at or past sample 5
    for (int m = 5; m <= 30; m++) begin
      @(negedge clk);
      e = (m <= t_sw) ? want(m, 1, 6, 3, 6) : want(m - t_sw, 2, 4, 1, 4);
      check(sclk_o, e, "R6 change lands at wrap");
      check(rise_tick_o, e && !prev, "R5 rise across change");
      check(fall_tick_o, !e && prev, "R5 fall across change");
      prev = e;
    end
    div_en = 1'b0;
  endtask

  task automatic t_disable_restart();
    @(negedge clk);
    div_en = 1'b0; idle_pol = 1'b1; cfg_word = pack(0, 2, 4, 2, 4);
    @(negedge clk); @(negedge clk);
    div_en = 1'b1;
    for (int m = 1; m <= 11; m++) @(negedge clk);
    check(sclk_o, want(11, 2, 4, 2, 4), "R9 mid-run level");
    div_en = 1'b0;
    @(negedge clk);
    check_idle(1'b1, "R9");
    div_en = 1'b1;
    for (int m = 1; m <= 16; m++) begin
      @(negedge clk);
      check(sclk_o, want(m, 2, 4, 2, 4), "R9 restart from zero");
    end
    div_en = 1'b0;
  endtask

  task automatic t_bypass();
    @(negedge clk);
    div_en = 1'b0; idle_pol = 1'b1; cfg_word = 32'd1;
    @(negedge clk); @(negedge clk);
    check_idle(1'b1, "R7 disabled bypass");
    div_en = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      check(sclk_o, 1'b1, "R7 follows clk high");
      @(negedge clk); #2;
      check(sclk_o, 1'b0, "R7 follows clk low");
      check(rise_tick_o, 1'b1, "R7 rise every cycle");
      check(fall_tick_o, 1'b1, "R7 fall every cycle");
    end
    @(negedge clk);
    div_en = 1'b0;
    @(negedge clk);
    check_idle(1'b1, "R7 bypass off");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle(1'b0, "R1 reset");
    rst_n = 1'b1;
    run_wave(1, 2, 1, 2, 1'b0, 12, "R2 R3 R4 fastest divide");
    run_wave(3, 5, 2, 5, 1'b0, 45, "R2 R3 R10 prescaled");
    run_wave(2, 8, 6, 8, 1'b1, 40, "R3 R4 high idle");
    run_wave(1, 8, 2, 5, 1'b0, 24, "R8 early return high");
    t_cfg_change();
    t_disable_restart();
    t_bypass();
    finish_run();
  end
endmodule